// File: doc/BRIEF.md
# Serial Address-Matched Attenuation Control Register

This block takes a serial control stream made of a data line, a shift clock and a latch-enable line. It assembles a 16-bit frame in a shift register and, on a latch, decides whether the frame is meant for this device. The frame holds an 8-bit attenuation word followed by an 8-bit address word. The frame is applied only when the low address bits equal the levels on the static address pins. The applied word has seven attenuation bits and a mode bit in bit 7, which must be cleared before a controller moves the device to parallel control.

All three serial inputs are oversampled in the system clock domain through a parameterised synchronizer. A rising edge of the serial clock shifts one bit while latch enable is low. A rising edge of latch enable evaluates the frame. A frame whose address does not match is dropped without a trace, and the last applied word stays in place. Each accepted frame raises a one-cycle strobe.

Top module: `sdsa_ctrl`

## Requirements
- R1: After reset the applied word is 0x7F, meaning all seven attenuation bits are set and the mode bit (bit 7) is clear. The accept strobe is low.
- R2: The frame is shifted in least significant bit first, one bit per rising edge of the serial clock. After 16 shifts the first bit sent sits in frame bit 0. Frame bits 7:0 are the attenuation word and frame bits 15:8 are the address word.
- R3: Shifting bits while latch enable is low never changes the applied word.
- R4: On a rising edge of latch enable, if the address matches, the applied word takes all eight bits of frame bits 7:0, including the mode bit in bit 7.
- R5: On a rising edge of latch enable with a mismatching address, the applied word keeps its previous value and no strobe is given.
- R6: Only frame bits 10:8 are compared with the address pins. Frame bits 15:11 have no effect on the match.
- R7: If more than 16 serial clocks arrive before a latch, the frame is made of the last 16 bits shifted in.
- R8: Each matching latch raises the accept strobe for exactly one system clock cycle. A falling edge of latch enable raises no strobe and changes nothing.
- R9: Serial clock edges that arrive while latch enable is high do not shift the register.
- R10: When a serial clock rising edge and a latch enable rising edge are seen in the same sample, no shift takes place. The latch evaluates the frame as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock; a rising edge shifts one bit |
| ser_le | input | 1 | Latch enable; a rising edge evaluates the frame |
| addr_pins | input | ADDR_BITS (3) | Static device address levels |
| att_word | output | WORD_W (8) | Applied word: attenuation bits 6:0, mode bit 7 |
| frame_ok | output | 1 | One-cycle strobe for an accepted frame |

## Verification
A serial clock rising edge and a latch enable rising edge can fall in the same system clock sample, so a shift and a latch compete in one cycle. The bench provokes this by driving the 16th data bit, the serial clock and latch enable high on the same clock edge after only 15 bits have been shifted. The expected result comes from the bench's own frame model with the final shift suppressed. The applied word and the strobe count must match a latch of that unshifted frame, whether its address field then matches or not.

// File: rtl/sdsa_pkg.sv
package sdsa_pkg;
   localparam int unsigned DEF_WORD_W    = 8;
   localparam int unsigned DEF_ATT_BITS  = 7;
   localparam int unsigned DEF_ADDR_BITS = 3;
   localparam int unsigned DEF_SYNC      = 2;

   // Index of each serial line inside the synchronised vector
   localparam int unsigned IDX_DATA = 0;
   localparam int unsigned IDX_SCLK = 1;
   localparam int unsigned IDX_LE   = 2;
   localparam int unsigned N_LINES  = 3;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_SHIFT = 2'd1,
      EV_LATCH = 2'd2
   } sdsa_event_e;
endpackage

// File: rtl/sdsa_sync.sv
module sdsa_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] staged;
   logic [WIDTH-1:0] prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign staged = d_in;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= d_in;
               for (int k = 1; k < int'(STAGES); k++) begin
                  pipe_q[k] <= pipe_q[k-1];
               end
            end
         end
         assign staged = pipe_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= staged;
   end

   assign lvl  = staged;
   assign rise = staged & ~prev_q;
endmodule

// File: rtl/sdsa_shift.sv
module sdsa_shift #(
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   output logic [FRAME_W-1:0] frame
);
   logic [FRAME_W-1:0] sr_q;

   // New bits enter at the top, so the first bit sent ends in bit 0
   always_ff @(posedge clk) begin
      if (!rst_n)        sr_q <= '0;
      else if (shift_en) sr_q <= {din, sr_q[FRAME_W-1:1]};
   end

   assign frame = sr_q;
endmodule

// File: rtl/sdsa_apply.sv
module sdsa_apply #(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned ATT_BITS  = 7,
   parameter int unsigned ADDR_BITS = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  latch_en,
   input  logic [2*WORD_W-1:0]   frame,
   input  logic [ADDR_BITS-1:0]  addr_pins,
   output logic [WORD_W-1:0]     att_word,
   output logic                  accepted
);
   localparam int unsigned MODE_BITS = WORD_W - ATT_BITS;
   localparam logic [WORD_W-1:0] RESET_WORD = {{MODE_BITS{1'b0}}, {ATT_BITS{1'b1}}};

   logic [WORD_W-1:0]    word_field;
   logic [ADDR_BITS-1:0] addr_field;
   logic                 hit;
   logic [WORD_W-1:0]    word_q;
   logic                 acc_q;

   assign word_field = frame[WORD_W-1:0];
   assign addr_field = frame[WORD_W +: ADDR_BITS];
   assign hit        = (addr_field == addr_pins);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= RESET_WORD;
         acc_q  <= 1'b0;
      end else begin
         acc_q <= latch_en & hit;
         if (latch_en && hit) word_q <= word_field;
      end
   end

   assign att_word = word_q;
   assign accepted = acc_q;
endmodule

// File: rtl/sdsa_ctrl.sv
module sdsa_ctrl #(
   parameter int unsigned WORD_W      = sdsa_pkg::DEF_WORD_W,
   parameter int unsigned ATT_BITS    = sdsa_pkg::DEF_ATT_BITS,
   parameter int unsigned ADDR_BITS   = sdsa_pkg::DEF_ADDR_BITS,
   parameter int unsigned SYNC_STAGES = sdsa_pkg::DEF_SYNC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_data,
   input  logic                 ser_clk,
   input  logic                 ser_le,
   input  logic [ADDR_BITS-1:0] addr_pins,
   output logic [WORD_W-1:0]    att_word,
   output logic                 frame_ok
);
   import sdsa_pkg::*;

   localparam int unsigned FRAME_W = 2 * WORD_W;

   generate
      if (ATT_BITS == 0 || ATT_BITS >= WORD_W) begin : g_bad_att
         $error("ATT_BITS must leave at least one mode bit in the word");
      end
      if (ADDR_BITS == 0 || ADDR_BITS > WORD_W) begin : g_bad_addr
         $error("ADDR_BITS must fit inside the address word");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] line_lvl;
   logic [N_LINES-1:0] line_rise;
   sdsa_event_e        evt;
   logic               shift_pulse;
   logic               latch_pulse;
   logic [FRAME_W-1:0] frame_q;

   always_comb begin
      raw_lines           = '0;
      raw_lines[IDX_DATA] = ser_data;
      raw_lines[IDX_SCLK] = ser_clk;
      raw_lines[IDX_LE]   = ser_le;
   end

   sdsa_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_lines),
      .lvl   (line_lvl),
      .rise  (line_rise)
   );

   // A latch edge wins over a clock edge seen in the same sample
   always_comb begin
      evt = EV_NONE;
      if (line_rise[IDX_LE])
         evt = EV_LATCH;
      else if (line_rise[IDX_SCLK] && !line_lvl[IDX_LE])
         evt = EV_SHIFT;
   end

   assign shift_pulse = (evt == EV_SHIFT);
   assign latch_pulse = (evt == EV_LATCH);

   sdsa_shift #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_pulse),
      .din      (line_lvl[IDX_DATA]),
      .frame    (frame_q)
   );

   sdsa_apply #(
      .WORD_W    (WORD_W),
      .ATT_BITS  (ATT_BITS),
      .ADDR_BITS (ADDR_BITS)
   ) u_apply (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_en  (latch_pulse),
      .frame     (frame_q),
      .addr_pins (addr_pins),
      .att_word  (att_word),
      .accepted  (frame_ok)
   );
endmodule

// File: rtl/sdsa_ctrl_chk.sv
module sdsa_ctrl_chk #(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned ADDR_BITS = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  shift_pulse,
   input logic                  latch_pulse,
   input logic [2*WORD_W-1:0]   frame_q,
   input logic [ADDR_BITS-1:0]  addr_pins,
   input logic [WORD_W-1:0]     att_word,
   input logic                  frame_ok
);
   localparam int unsigned FRAME_W = 2 * WORD_W;

   // R2: each shift moves the frame down by one place
   a_r2_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> frame_q[FRAME_W-2:0] == $past(frame_q[FRAME_W-1:1]));

   // R3: shifting never touches the applied word
   a_r3_hold_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> $stable(att_word));

   // R4: a matching latch loads the word field and strobes
   a_r4_match_load: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_pulse && frame_q[WORD_W +: ADDR_BITS] == addr_pins)
      |=> (att_word == $past(frame_q[WORD_W-1:0])) && frame_ok);

   // R4: the applied word only moves together with the strobe
   a_r4_change_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(att_word) |-> frame_ok);

   // R5: a mismatching latch keeps the word and stays silent
   a_r5_mismatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_pulse && frame_q[WORD_W +: ADDR_BITS] != addr_pins)
      |=> $stable(att_word) && !frame_ok);

   // R8: the strobe lasts a single cycle
   a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);

   // R9: without a shift the frame is frozen
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_pulse |=> $stable(frame_q));
endmodule

bind sdsa_ctrl sdsa_ctrl_chk #(
   .WORD_W    (WORD_W),
   .ADDR_BITS (ADDR_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .shift_pulse (shift_pulse),
   .latch_pulse (latch_pulse),
   .frame_q     (frame_q),
   .addr_pins   (addr_pins),
   .att_word    (att_word),
   .frame_ok    (frame_ok)
);

// File: tb/sim_sdsa_ctrl.sv
module sim_sdsa_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_le = 1'b0;
   logic [2:0] addr_pins = 3'd0;
   logic [7:0] att_word;
   logic       frame_ok;

   int checks = 0;
   int errors = 0;
   int acc_seen = 0;
   int acc_exp = 0;
   bit done = 1'b0;

   logic [15:0] m_sr = 16'h0000;
   logic [7:0]  m_att = 8'h7F;

   always #4 clk = ~clk;

   sdsa_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_data  (ser_data),
      .ser_clk   (ser_clk),
      .ser_le    (ser_le),
      .addr_pins (addr_pins),
      .att_word  (att_word),
      .frame_ok  (frame_ok)
   );

   always @(posedge clk) if (rst_n && frame_ok) acc_seen++;

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      ser_data = b;
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(4);
      m_sr = {b, m_sr[15:1]};
   endtask

   task automatic model_latch();
      if (m_sr[10:8] == addr_pins) begin
         m_att = m_sr[7:0];
         acc_exp++;
      end
   endtask

   task automatic pulse_le();
      ser_le = 1'b1;
      wait_cyc(6);
      model_latch();
      ser_le = 1'b0;
      wait_cyc(6);
   endtask

   task automatic send_frame(input logic [7:0] addr_w, input logic [7:0] att_w);
      logic [15:0] f;
      f = {addr_w, att_w};
      for (int i = 0; i < 16; i++) shift_bit(f[i]);
   endtask

   task automatic judge(input string req);
      chk8(req, att_word, m_att);
      chk_int(req, acc_seen, acc_exp);
   endtask

   initial begin
      wait_cyc(5);
      // R1: reset state
      chk8("R1 reset word", att_word, 8'h7F);
      chk8("R1 reset strobe", {7'd0, frame_ok}, 8'h00);
      rst_n = 1'b1;
      wait_cyc(4);
      chk8("R1 after release", att_word, 8'h7F);

      // R2/R4/R5/R8: sweep pins and address values
      for (int p = 0; p < 8; p += 3) begin
         addr_pins = 3'(p);
         for (int a = 0; a < 8; a++) begin
            send_frame(8'((a * 40) | a), 8'((p * 37 + a * 11 + 3) & 8'hFF));
            pulse_le();
            judge((a == p) ? "R4 match sweep" : "R5 mismatch sweep");
         end
      end
      addr_pins = 3'd7;
      send_frame(8'h07, 8'h5A);
      pulse_le();
      judge("R2 lsb first frame");

      // R3: half a frame entered, applied word untouched
      send_frame(8'h07, 8'h11);
      for (int i = 0; i < 8; i++) shift_bit(1'(i & 1));
      chk8("R3 no change while shifting", att_word, m_att);
      for (int i = 0; i < 8; i++) shift_bit(1'b0);
      pulse_le();
      judge("R3 completed frame");

      // R6: upper address bits ignored
      addr_pins = 3'd2;
      send_frame(8'hFA, 8'h23);
      pulse_le();
      judge("R6 upper address bits");
      chk8("R6 word value", att_word, 8'h23);

      // R4: mode bit carried in bit 7
      send_frame(8'h02, 8'h80);
      pulse_le();
      judge("R4 mode bit set");
      chk8("R4 mode bit value", att_word, 8'h80);

      // R7: 20 clocks, last 16 used
      for (int i = 0; i < 4; i++) shift_bit(1'b1);
      send_frame(8'h02, 8'h46);
      pulse_le();
      judge("R7 overlong burst");
      chk8("R7 value", att_word, 8'h46);

      // R9: clocks with latch enable high do not shift
      send_frame(8'h02, 8'h19);
      ser_le = 1'b1;
      wait_cyc(6);
      model_latch();
      for (int i = 0; i < 3; i++) begin
         ser_data = 1'b1;
         wait_cyc(3);
         ser_clk = 1'b1;
         wait_cyc(3);
         ser_clk = 1'b0;
         wait_cyc(3);
      end
      ser_le = 1'b0;
      wait_cyc(6);
      // R8: falling edge gave no strobe
      judge("R8 falling edge silent");
      pulse_le();
      judge("R9 frame unchanged by clocks");
      chk8("R9 value", att_word, 8'h19);

      // R10: clock and latch edges together, for several frames
      for (int t = 0; t < 4; t++) begin
         logic [15:0] f;
         f = {8'(t * 2), 8'(8'h31 + t * 17)};
         for (int i = 0; i < 15; i++) shift_bit(f[i]);
         ser_data = f[15];
         ser_clk = 1'b1;
         ser_le = 1'b1;
         wait_cyc(6);
         model_latch();
         ser_clk = 1'b0;
         ser_le = 1'b0;
         wait_cyc(6);
         judge("R10 coincident edges");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule